// File: doc/BRIEF.md
# Coefficient Reload Port

This block holds the coefficient banks of a multi-bank filter and lets a processor inspect or rewrite them through a simple memory-mapped port while the filter keeps running. The processor side has its own clock. A write is taken into a bus-side copy at once and is then moved into the filter-side copy through a toggle handshake. The filter therefore only ever sees complete coefficient words.

The filter side picks a bank and a tap and receives the stored coefficient one filter clock later. Elaboration parameters set the access mode: reads only, writes only, or both. A separate parameter can disable reloading altogether. Before any write is accepted, a dedicated reload reset input must go high and then low again. The intended flow is to rewrite a bank the filter is not using and then switch the filter's bank select over to it.

Top module: `coef_reload_port`

## Requirements
- R1: After reset, read-valid and read data are 0 and every stored coefficient is 0 on the filter side.
- R2: A bus address A in the window BASE .. BASE+BANKS*TAPS-1 selects word A-BASE = bank*TAPS + tap. With the defaults (BASE 0x20, TAPS 8), address 0x35 is bank 2, tap 5.
- R3: An accepted read (read request high, address in the window, reads allowed) raises read-valid for exactly the next bus cycle, with read data equal to the stored coefficient.
- R4: An address outside the window never raises read-valid and returns read data 0, and a write to it changes no coefficient.
- R5: In write-only mode, reads never raise read-valid. In read-only mode, writes change nothing. In read/write mode, both reads and writes work.
- R6: With reloading disabled, reads never raise read-valid and writes change nothing on either side.
- R7: Writes are ignored until the reload reset input has been high and then returned low. Writes are also ignored while that input is high.
- R8: An accepted write reaches the filter side as a whole word within a few cycles. A write issued while an earlier one is still crossing is dropped.
- R9: The filter-side coefficient is registered and follows a change of bank or tap select after one filter clock edge.
- R10: Rewriting one bank leaves the coefficient the filter reads from a different bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Processor-side clock |
| bus_rst_n | input | 1 | Processor-side reset, active low |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | COEF_W | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read request |
| bus_rdata | output | COEF_W | Read data, 0 when not valid |
| bus_rvalid | output | 1 | Read data valid |
| coef_rst | input | 1 | Reload reset; must pulse before writes are accepted |
| flt_clk | input | 1 | Filter clock |
| flt_rst_n | input | 1 | Filter-side reset, active low |
| flt_bank | input | $clog2(BANKS) | Filter bank select |
| flt_tap | input | $clog2(TAPS) | Filter tap select |
| flt_coef | output | COEF_W | Selected coefficient, registered |

## Verification
The assertions assume that read and write requests are single-cycle strobes in the bus domain. They also assume that both resets are released together, so that the two handshake toggles start out aligned. The bench drives every bus input on the falling edge of the bus clock. It keeps each strobe to one cycle and waits well over a full handshake round trip before checking the filter side. The only exception is the deliberate back-to-back write that exercises the drop rule. The bank and tap selects change on the falling edge of the filter clock, so they never violate a filter-domain register.

// File: rtl/coef_reload_pkg.sv
package coef_reload_pkg;
   typedef enum logic [1:0] {
      ACC_RD = 2'd0,
      ACC_WR = 2'd1,
      ACC_RW = 2'd2
   } acc_mode_e;
endpackage

// File: rtl/coef_addr_dec.sv
// Window decode: hit when addr lies in [BASE, BASE+DEPTH), idx = addr - BASE.
module coef_addr_dec #(
   parameter int ADDR_W = 8,
   parameter int BASE   = 32,
   parameter int DEPTH  = 32,
   parameter int IDX_W  = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);
   localparam int EXT_W = ADDR_W + 1;
   logic [EXT_W-1:0] off;

   always_comb begin
      off = {1'b0, addr} - EXT_W'(BASE);
      hit = ({1'b0, addr} >= EXT_W'(BASE)) && (off < EXT_W'(DEPTH));
      idx = off[IDX_W-1:0];
   end
endmodule

// File: rtl/coef_store.sv
// Word array with one write port and one registered read port.
module coef_store #(
   parameter int W     = 16,
   parameter int DEPTH = 32,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [W-1:0]     wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [W-1:0]     rdata
);
   logic [W-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (we && (widx == IDX_W'(i)))
            mem[i] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= mem[ridx];
   end
endmodule

// File: rtl/coef_cdc_xfer.sv
// Toggle handshake: the held word is stable from launch until the ack returns.
module coef_cdc_xfer #(
   parameter int W      = 16,
   parameter int IDX_W  = 5,
   parameter int SYNC_N = 2
) (
   input  logic             b_clk,
   input  logic             b_rst_n,
   input  logic             launch,
   input  logic [IDX_W-1:0] l_idx,
   input  logic [W-1:0]     l_data,
   output logic             busy,
   output logic [IDX_W-1:0] h_idx,
   output logic [W-1:0]     h_data,
   input  logic             f_clk,
   input  logic             f_rst_n,
   output logic             f_we
);
   logic              req_t;
   logic [SYNC_N-1:0] ack_s;
   logic [SYNC_N:0]   req_s;

   always_ff @(posedge b_clk or negedge b_rst_n) begin
      if (!b_rst_n) begin
         req_t  <= 1'b0;
         h_idx  <= '0;
         h_data <= '0;
         ack_s  <= '0;
      end else begin
         ack_s <= {ack_s[SYNC_N-2:0], req_s[SYNC_N]};
         if (launch) begin
            req_t  <= ~req_t;
            h_idx  <= l_idx;
            h_data <= l_data;
         end
      end
   end

   always_ff @(posedge f_clk or negedge f_rst_n) begin
      if (!f_rst_n) req_s <= '0;
      else          req_s <= {req_s[SYNC_N-1:0], req_t};
   end

   assign busy = req_t ^ ack_s[SYNC_N-1];
   assign f_we = req_s[SYNC_N-1] ^ req_s[SYNC_N];
endmodule

// File: rtl/coef_reload_port.sv
module coef_reload_port
   import coef_reload_pkg::*;
#(
   parameter int        COEF_W    = 16,
   parameter int        TAPS      = 8,
   parameter int        BANKS     = 4,
   parameter int        ADDR_W    = 8,
   parameter int        BASE      = 32,
   parameter acc_mode_e MODE      = ACC_RW,
   parameter bit        RELOAD_EN = 1'b1,
   parameter int        SYNC_N    = 2,
   localparam int       TAP_W     = $clog2(TAPS),
   localparam int       BANK_W    = $clog2(BANKS)
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [COEF_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [COEF_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   input  logic              coef_rst,
   input  logic              flt_clk,
   input  logic              flt_rst_n,
   input  logic [BANK_W-1:0] flt_bank,
   input  logic [TAP_W-1:0]  flt_tap,
   output logic [COEF_W-1:0] flt_coef
);
   localparam int DEPTH = BANKS * TAPS;
   localparam int IDX_W = TAP_W + BANK_W;
   localparam bit RD_OK = RELOAD_EN && (MODE != ACC_WR);
   localparam bit WR_OK = RELOAD_EN && (MODE != ACC_RD);

   if ((1 << TAP_W) != TAPS || TAPS < 2)
      $error("TAPS must be a power of two, at least 2");
   if ((1 << BANK_W) != BANKS || BANKS < 2)
      $error("BANKS must be a power of two, at least 2");
   if (BASE < 0 || BASE + DEPTH > (1 << ADDR_W))
      $error("address window does not fit ADDR_W");
   if (SYNC_N < 2)
      $error("SYNC_N must be at least 2");

   logic              hit;
   logic [IDX_W-1:0]  idx;
   logic              rst_q, armed;
   logic              busy, rd_acc, wr_acc, rvalid_q, f_we;
   logic [IDX_W-1:0]  x_idx;
   logic [COEF_W-1:0] x_data, sh_q;

   coef_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_dec (
      .addr(bus_addr), .hit(hit), .idx(idx)
   );

   // Reload gate: armed on the falling edge of coef_rst.
   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         rst_q <= 1'b0;
         armed <= 1'b0;
      end else begin
         rst_q <= coef_rst;
         if (rst_q && !coef_rst) armed <= 1'b1;
      end
   end

   assign rd_acc = RD_OK && bus_re && hit;
   assign wr_acc = WR_OK && bus_we && hit && armed && !coef_rst && !busy;

   coef_cdc_xfer #(.W(COEF_W), .IDX_W(IDX_W), .SYNC_N(SYNC_N)) u_xfer (
      .b_clk(bus_clk), .b_rst_n(bus_rst_n), .launch(wr_acc),
      .l_idx(idx), .l_data(bus_wdata), .busy(busy),
      .h_idx(x_idx), .h_data(x_data),
      .f_clk(flt_clk), .f_rst_n(flt_rst_n), .f_we(f_we)
   );

   if (RD_OK) begin : g_shadow
      coef_store #(.W(COEF_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_shadow (
         .clk(bus_clk), .rst_n(bus_rst_n), .we(wr_acc), .widx(idx),
         .wdata(bus_wdata), .ridx(idx), .rdata(sh_q)
      );
   end else begin : g_no_shadow
      assign sh_q = '0;
   end

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) rvalid_q <= 1'b0;
      else            rvalid_q <= rd_acc;
   end

   assign bus_rvalid = rvalid_q;
   assign bus_rdata  = rvalid_q ? sh_q : '0;

   coef_store #(.W(COEF_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_fstore (
      .clk(flt_clk), .rst_n(flt_rst_n), .we(f_we), .widx(x_idx),
      .wdata(x_data), .ridx({flt_bank, flt_tap}), .rdata(flt_coef)
   );
endmodule

// File: rtl/coef_reload_chk.sv
module coef_reload_chk #(
   parameter int COEF_W = 16,
   parameter bit RD_OK  = 1'b1
) (
   input logic              bus_clk,
   input logic              bus_rst_n,
   input logic              bus_re,
   input logic              bus_we,
   input logic              coef_rst,
   input logic              bus_rvalid,
   input logic [COEF_W-1:0] bus_rdata,
   input logic              busy,
   input logic [COEF_W-1:0] x_data
);
   p_rvalid_after_re_r3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      bus_rvalid |-> $past(bus_re));

   p_rdata_quiet_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      !bus_rvalid |-> (bus_rdata == '0));

   p_busy_from_write_r8: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      $rose(busy) |-> $past(bus_we));

   p_gate_holds_r7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (coef_rst && bus_we) |=> !$rose(busy));

   p_word_held_r8: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (busy && $past(busy)) |-> $stable(x_data));

   if (!RD_OK) begin : g_no_read
      p_no_rvalid_r5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
         bus_re |=> !bus_rvalid);
   end
endmodule

bind coef_reload_port coef_reload_chk #(.COEF_W(COEF_W), .RD_OK(RD_OK)) u_chk (
   .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_re(bus_re), .bus_we(bus_we),
   .coef_rst(coef_rst), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
   .busy(busy), .x_data(x_data)
);

// File: tb/sim_coef_reload_port.sv
`timescale 1ns/1ps
module sim_coef_reload_port;
   import coef_reload_pkg::*;

   logic       bus_clk = 0, flt_clk = 0;
   logic       bus_rst_n = 0, flt_rst_n = 0;
   logic [7:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic       bus_we = 0, bus_re = 0, coef_rst = 0;
   logic [1:0] flt_bank = '0;
   logic [2:0] flt_tap = '0;

   logic [15:0] rd0, rd1, rd2, rd3, fc0, fc1, fc2, fc3;
   logic        rv0, rv1, rv2, rv3;

   int checks = 0, errors = 0;

   always #5   bus_clk = ~bus_clk;
   always #3.5 flt_clk = ~flt_clk;

   coef_reload_port #(.MODE(ACC_RW)) u0 (.bus_clk, .bus_rst_n, .bus_addr, .bus_wdata,
      .bus_we, .bus_re, .bus_rdata(rd0), .bus_rvalid(rv0), .coef_rst, .flt_clk,
      .flt_rst_n, .flt_bank, .flt_tap, .flt_coef(fc0));
   coef_reload_port #(.MODE(ACC_WR)) u1 (.bus_clk, .bus_rst_n, .bus_addr, .bus_wdata,
      .bus_we, .bus_re, .bus_rdata(rd1), .bus_rvalid(rv1), .coef_rst, .flt_clk,
      .flt_rst_n, .flt_bank, .flt_tap, .flt_coef(fc1));
   coef_reload_port #(.MODE(ACC_RD)) u2 (.bus_clk, .bus_rst_n, .bus_addr, .bus_wdata,
      .bus_we, .bus_re, .bus_rdata(rd2), .bus_rvalid(rv2), .coef_rst, .flt_clk,
      .flt_rst_n, .flt_bank, .flt_tap, .flt_coef(fc2));
   coef_reload_port #(.RELOAD_EN(1'b0)) u3 (.bus_clk, .bus_rst_n, .bus_addr, .bus_wdata,
      .bus_we, .bus_re, .bus_rdata(rd3), .bus_rvalid(rv3), .coef_rst, .flt_clk,
      .flt_rst_n, .flt_bank, .flt_tap, .flt_coef(fc3));

   localparam int NV = 6;
   localparam logic [7:0]  VA [NV] = '{8'h20, 8'h27, 8'h29, 8'h2E, 8'h35, 8'h3F};
   localparam logic [15:0] VD [NV] = '{16'h1111, 16'hA5A5, 16'h7FFF, 16'h8000, 16'h0F0F, 16'hFFFF};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
      @(negedge bus_clk);
      bus_addr = a; bus_wdata = d; bus_we = 1;
      @(negedge bus_clk);
      bus_we = 0;
   endtask

   task automatic settle();
      repeat (20) @(negedge bus_clk);
   endtask

   task automatic bus_read(input logic [7:0] a);
      @(negedge bus_clk);
      bus_addr = a; bus_re = 1;
      @(negedge bus_clk);
      bus_re = 0;
   endtask

   task automatic flt_look(input logic [7:0] a);
      logic [7:0] off;
      off = a - 8'h20;
      @(negedge flt_clk);
      flt_bank = off[4:3]; flt_tap = off[2:0];
      @(posedge flt_clk);
      #1;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge bus_clk);
      bus_rst_n = 1; flt_rst_n = 1;
      @(negedge bus_clk);
      // R1: reset state
      chk("R1 rvalid", 32'(rv0), 0);
      chk("R1 rdata", 32'(rd0), 0);
      flt_look(8'h20);
      chk("R1 filter coef", 32'(fc0), 0);

      // R7: no write before the reload reset pulse
      bus_write(8'h21, 16'h1234); settle();
      bus_read(8'h21);
      chk("R7 unarmed rvalid", 32'(rv0), 1);
      chk("R7 unarmed write ignored", 32'(rd0), 0);
      @(negedge bus_clk); coef_rst = 1;
      bus_write(8'h21, 16'h4321); settle();
      bus_read(8'h21);
      chk("R7 write during reset ignored", 32'(rd0), 0);
      @(negedge bus_clk); coef_rst = 0;
      @(negedge bus_clk);

      // R2/R3/R8: vector table
      for (int i = 0; i < NV; i++) begin
         bus_write(VA[i], VD[i]); settle();
         bus_read(VA[i]);
         chk("R3 rvalid", 32'(rv0), 1);
         chk("R3 rdata", 32'(rd0), 32'(VD[i]));
         @(negedge bus_clk);
         chk("R3 rvalid one cycle", 32'(rv0), 0);
         flt_look(VA[i]);
         chk("R2 filter bank/tap", 32'(fc0), 32'(VD[i]));
      end

      // R4: outside window
      bus_read(8'h40);
      chk("R4 high rvalid", 32'(rv0), 0);
      chk("R4 high rdata", 32'(rd0), 0);
      bus_read(8'h1F);
      chk("R4 low rvalid", 32'(rv0), 0);
      bus_write(8'h40, 16'hDEAD); settle();
      bus_read(8'h20);
      chk("R4 out-of-window write", 32'(rd0), 32'(VD[0]));

      // R8: back-to-back second write dropped
      @(negedge bus_clk);
      bus_addr = 8'h22; bus_wdata = 16'hAAAA; bus_we = 1;
      @(negedge bus_clk);
      bus_addr = 8'h23; bus_wdata = 16'hBBBB;
      @(negedge bus_clk);
      bus_we = 0;
      settle();
      bus_read(8'h22);
      chk("R8 first write kept", 32'(rd0), 32'h0000AAAA);
      bus_read(8'h23);
      chk("R8 busy write dropped", 32'(rd0), 0);
      flt_look(8'h23);
      chk("R8 filter dropped", 32'(fc0), 0);
      flt_look(8'h22);
      chk("R8 filter whole word", 32'(fc0), 32'h0000AAAA);

      // R9: one filter edge latency
      flt_look(8'h27);
      chk("R9 tap follows in one edge", 32'(fc0), 32'(VD[1]));

      // R10: other bank rewritten while filter reads bank 0
      flt_look(8'h20);
      begin
         int changes = 0;
         bus_write(8'h30, 16'h5555);
         for (int k = 0; k < 30; k++) begin
            @(posedge flt_clk); #1;
            if (fc0 !== VD[0]) changes++;
         end
         chk("R10 active bank unchanged", 32'(changes), 0);
      end
      flt_look(8'h30);
      chk("R10 new bank ready", 32'(fc0), 32'h00005555);

      // R5: mode variants
      bus_read(8'h20);
      chk("R5 write-only no rvalid", 32'(rv1), 0);
      chk("R5 read-only rvalid", 32'(rv2), 1);
      chk("R5 read-only write ignored", 32'(rd2), 0);
      flt_look(8'h20);
      chk("R5 write-only filter updated", 32'(fc1), 32'(VD[0]));
      chk("R5 read-only filter untouched", 32'(fc2), 0);

      // R6: disabled
      bus_read(8'h20);
      chk("R6 disabled no rvalid", 32'(rv3), 0);
      chk("R6 disabled filter untouched", 32'(fc3), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule